// File: doc/BRIEF.md
# Sv39 Page Table Walker

This block resolves a virtual page number into its leaf page table entry on behalf of two translation buffers, one on the instruction side and one on the data side. Starting from the root page number held in the address-translation register, it reads up to three levels of the three-level page tree. Every read goes through one memory read port, which the block shares with the data cache. When the walk ends, the block returns either the leaf entry and the level at which it was found, or a page fault or access fault.

Each buffer raises its request line with a virtual page number and keeps it high until it sees its own one-cycle response pulse. The payload of the response (entry, level, fault flags) is shared between the two sides, and the valid strobe says which side it is for. When the data side owns a walk, the block raises a signal that keeps the core pipeline off the data cache until the walk ends.

Top module: `sv39_walker`

## Requirements
- R1: The first read of a walk targets root_ppn*4096 + VPN[26:18]*8 (level 2). Every later read targets P*4096 + idx*8, where P is bits 53:10 of the entry just read and idx is the next lower 9-bit slice of the virtual page number (VPN[17:9] for level 1, VPN[8:0] for level 0).
- R2: While mem_req_valid is high and mem_req_ready is low, the request stays asserted and mem_req_addr does not change.
- R3: An entry with bit 1 (read) or bit 3 (execute) set is a leaf. The walk ends there and returns the whole entry, with rsp_level equal to 2, 1 or 0 for the level at which it was found, and no fault flag.
- R4: A memory response with mem_rsp_err set ends the walk. The next cycle returns an access fault (rsp_access_fault=1, rsp_page_fault=0), and the walk issues no further reads.
- R5: An entry with bit 0 (valid) clear, or with bit 2 (write) set and bit 1 clear, ends the walk with a page fault.
- R6: A leaf found at level 1 or level 2 ends with a page fault when the low 9*level bits of its page number are not all zero.
- R7: A non-leaf entry found at level 0 ends the walk with a page fault.
- R8: The response goes only to the side that owns the walk. It is a single-cycle pulse, asserted in the cycle after the final memory response.
- R9: When both request lines are high in the same idle cycle, the data side is served first. The instruction side waits and is served once the data walk has responded.
- R10: dcache_block is high from the cycle after a data-side request is accepted through its response cycle. It stays low during instruction-side walks and while the block is idle.
- R11: After reset the block is idle, with no memory request, no response and dcache_block low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_ppn | input | 44 | Root table page number from the translation register |
| i_req | input | 1 | Instruction-side request, held until its response |
| i_vpn | input | 27 | Instruction-side virtual page number |
| i_rsp_valid | output | 1 | Response strobe for the instruction side |
| d_req | input | 1 | Data-side request, held until its response |
| d_vpn | input | 27 | Data-side virtual page number |
| d_rsp_valid | output | 1 | Response strobe for the data side |
| rsp_pte | output | 64 | Leaf entry (zero on a fault) |
| rsp_level | output | 2 | Level at which the walk ended |
| rsp_page_fault | output | 1 | Page fault flag |
| rsp_access_fault | output | 1 | Access fault flag |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 56 | Physical address of the entry |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_err | input | 1 | Memory read trapped or failed |
| mem_rsp_data | input | 64 | Entry read from memory |
| dcache_block | output | 1 | Keeps the pipeline off the data cache |

## Verification
Two things can fall in the same idle cycle: a request from the instruction side and a request from the data side, so the block's arbitration and the start of the walk coincide. The bench raises both request lines on the same clock edge. It checks that the first response strobe is the data-side one and carries the data walk's result. It then checks that the instruction request, still held high, is served next with its own result, that the read addresses of both walks are correct, and that dcache_block stays low for the whole of the instruction walk.

// File: rtl/ptw_pkg.sv
// Package: shared state and ownership encodings for the page table walker.
// Assumes: nothing beyond IEEE 1800-2017.
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } walk_state_e;

    typedef enum logic {
        OWN_INSTR = 1'b0,
        OWN_DATA  = 1'b1
    } walk_owner_e;

endpackage

// File: rtl/ptw_arb.sv
// Module: fixed-priority selector between the two translation buffers.
// Grants only while the walker is idle; the data side always wins.
// Assumes: requesters hold their request lines until answered.
module ptw_arb (
    input  logic idle,
    input  logic i_req,
    input  logic d_req,
    output logic take,
    output logic take_data
);

    // Grant decision for the current idle cycle.
    always_comb begin
        take      = idle && (i_req || d_req);
        take_data = d_req;
    end

endmodule

// File: rtl/ptw_addr.sv
// Module: forms the physical address of the entry to read at a level.
// Address = page number * 2^OFF_W + index * 8, index taken from the VPN slice.
// Assumes: IDX_W + 3 <= OFF_W (an index never reaches the page number bits).
module ptw_addr #(
    parameter int PPN_W  = 44,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int LEVELS = 3,
    parameter int LVL_W  = 2,
    parameter int VPN_W  = IDX_W * LEVELS,
    parameter int PA_W   = PPN_W + OFF_W
) (
    input  logic [PPN_W-1:0] ppn,
    input  logic [VPN_W-1:0] vpn,
    input  logic [LVL_W-1:0] level,
    output logic [PA_W-1:0]  addr
);

    localparam int ENT_SH = 3;

    logic [IDX_W-1:0] idx;

    // Select the VPN slice belonging to the current level.
    always_comb begin
        idx = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (level == LVL_W'(l)) begin
                idx = vpn[IDX_W*l +: IDX_W];
            end
        end
    end

    // Concatenate page base and scaled index.
    always_comb begin
        addr = {ppn, {OFF_W{1'b0}}};
        addr[IDX_W+ENT_SH-1:0] = {idx, {ENT_SH{1'b0}}};
    end

endmodule

// File: rtl/ptw_pte_chk.sv
// Module: classifies one page table entry read at a given level.
// Reports leaf/pointer, any page fault condition, and the next page number.
// Assumes: flag bits valid/read/write/execute at 0/1/2/3, page number at bit 10.
module ptw_pte_chk #(
    parameter int PTE_W  = 64,
    parameter int PPN_W  = 44,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 3,
    parameter int LVL_W  = 2
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [LVL_W-1:0] level,
    output logic             is_leaf,
    output logic             pg_fault,
    output logic [PPN_W-1:0] next_ppn
);

    localparam int PPN_LSB = 10;

    logic             f_v, f_r, f_w, f_x;
    logic [PPN_W-1:0] low_mask;
    logic             misaligned;
    logic             malformed;
    logic             unused_bits;

    // Split flag and page number fields.
    always_comb begin
        f_v      = pte[0];
        f_r      = pte[1];
        f_w      = pte[2];
        f_x      = pte[3];
        next_ppn = pte[PPN_LSB +: PPN_W];
    end

    assign unused_bits = ^{pte[PTE_W-1:PPN_LSB+PPN_W], pte[PPN_LSB-1:4]};

    // Mask of page number bits that must be zero for a superpage leaf.
    always_comb begin
        low_mask = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (level == LVL_W'(l)) begin
                low_mask = (PPN_W'(1) << (IDX_W * l)) - PPN_W'(1);
            end
        end
    end

    // Combine the fault conditions.
    always_comb begin
        is_leaf    = f_r || f_x;
        malformed  = !f_v || (f_w && !f_r);
        misaligned = is_leaf && ((next_ppn & low_mask) != '0);
        pg_fault   = malformed || misaligned || (!is_leaf && (level == '0));
    end

endmodule

// File: rtl/sv39_walker.sv
// Module: two-client page table walker for a three-level tree.
// Takes one request at a time from an instruction or data buffer (data first),
// reads entries through a shared memory port and answers the owner with the
// leaf entry or a fault. Blocks the data cache from the pipeline while a
// data-side walk is in flight.
// Assumes: requesters hold req until their rsp pulse and drop it right after;
// memory returns one response per accepted request, at least one cycle later.
module sv39_walker
    import ptw_pkg::*;
#(
    parameter int PTE_W  = 64,
    parameter int PPN_W  = 44,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int LEVELS = 3,
    parameter int LVL_W  = $clog2(LEVELS),
    parameter int VPN_W  = IDX_W * LEVELS,
    parameter int PA_W   = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PPN_W-1:0] root_ppn,
    input  logic             i_req,
    input  logic [VPN_W-1:0] i_vpn,
    output logic             i_rsp_valid,
    input  logic             d_req,
    input  logic [VPN_W-1:0] d_vpn,
    output logic             d_rsp_valid,
    output logic [PTE_W-1:0] rsp_pte,
    output logic [LVL_W-1:0] rsp_level,
    output logic             rsp_page_fault,
    output logic             rsp_access_fault,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic             mem_rsp_err,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             dcache_block
);

    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

    walk_state_e      state_q;
    walk_owner_e      owner_q;
    logic [LVL_W-1:0] level_q;
    logic [PPN_W-1:0] ppn_q;
    logic [VPN_W-1:0] vpn_q;

    logic             take, take_data;
    logic             is_leaf, pg_fault;
    logic [PPN_W-1:0] next_ppn;

    ptw_arb u_arb (
        .idle      (state_q == ST_IDLE),
        .i_req     (i_req),
        .d_req     (d_req),
        .take      (take),
        .take_data (take_data)
    );

    ptw_addr #(
        .PPN_W (PPN_W), .IDX_W (IDX_W), .OFF_W (OFF_W),
        .LEVELS(LEVELS), .LVL_W (LVL_W), .VPN_W (VPN_W), .PA_W (PA_W)
    ) u_addr (
        .ppn   (ppn_q),
        .vpn   (vpn_q),
        .level (level_q),
        .addr  (mem_req_addr)
    );

    ptw_pte_chk #(
        .PTE_W (PTE_W), .PPN_W (PPN_W), .IDX_W (IDX_W),
        .LEVELS(LEVELS), .LVL_W (LVL_W)
    ) u_chk (
        .pte      (mem_rsp_data),
        .level    (level_q),
        .is_leaf  (is_leaf),
        .pg_fault (pg_fault),
        .next_ppn (next_ppn)
    );

    // Walk sequencer: accept, issue, wait, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q          <= ST_IDLE;
            owner_q          <= OWN_INSTR;
            level_q          <= TOP_LVL;
            ppn_q            <= '0;
            vpn_q            <= '0;
            rsp_pte          <= '0;
            rsp_level        <= '0;
            rsp_page_fault   <= 1'b0;
            rsp_access_fault <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        owner_q <= take_data ? OWN_DATA : OWN_INSTR;
                        vpn_q   <= take_data ? d_vpn : i_vpn;
                        ppn_q   <= root_ppn;
                        level_q <= TOP_LVL;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        rsp_level <= level_q;
                        if (mem_rsp_err) begin
                            rsp_pte          <= '0;
                            rsp_page_fault   <= 1'b0;
                            rsp_access_fault <= 1'b1;
                            state_q          <= ST_RESP;
                        end else if (pg_fault) begin
                            rsp_pte          <= '0;
                            rsp_page_fault   <= 1'b1;
                            rsp_access_fault <= 1'b0;
                            state_q          <= ST_RESP;
                        end else if (is_leaf) begin
                            rsp_pte          <= mem_rsp_data;
                            rsp_page_fault   <= 1'b0;
                            rsp_access_fault <= 1'b0;
                            state_q          <= ST_RESP;
                        end else begin
                            ppn_q   <= next_ppn;
                            level_q <= level_q - LVL_W'(1);
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Port-level strobes decoded from the sequencer state.
    always_comb begin
        mem_req_valid = (state_q == ST_ISSUE);
        i_rsp_valid   = (state_q == ST_RESP) && (owner_q == OWN_INSTR);
        d_rsp_valid   = (state_q == ST_RESP) && (owner_q == OWN_DATA);
        dcache_block  = (state_q != ST_IDLE) && (owner_q == OWN_DATA);
    end

endmodule

// File: rtl/sv39_walker_chk.sv
// Module: protocol checker for the page table walker, attached by bind.
// Assumes: in_wait is high while the walker waits for a memory response.
module sv39_walker_chk #(
    parameter int PA_W = 56
) (
    input logic            clk,
    input logic            rst_n,
    input logic            i_rsp_valid,
    input logic            d_rsp_valid,
    input logic            rsp_page_fault,
    input logic            rsp_access_fault,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            mem_rsp_err,
    input logic            dcache_block,
    input logic            in_wait
);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R4
    err_to_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && mem_rsp_valid && mem_rsp_err) |=>
            ((i_rsp_valid || d_rsp_valid) && rsp_access_fault && !rsp_page_fault));

    // R8
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(i_rsp_valid && d_rsp_valid));

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i_rsp_valid || d_rsp_valid) |=> !(i_rsp_valid || d_rsp_valid));

    // R10
    blk_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_rsp_valid |-> dcache_block);

    // R10
    blk_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        i_rsp_valid |-> !dcache_block);

endmodule

bind sv39_walker sv39_walker_chk #(.PA_W(PA_W)) u_walk_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .i_rsp_valid      (i_rsp_valid),
    .d_rsp_valid      (d_rsp_valid),
    .rsp_page_fault   (rsp_page_fault),
    .rsp_access_fault (rsp_access_fault),
    .mem_req_valid    (mem_req_valid),
    .mem_req_ready    (mem_req_ready),
    .mem_req_addr     (mem_req_addr),
    .mem_rsp_valid    (mem_rsp_valid),
    .mem_rsp_err      (mem_rsp_err),
    .dcache_block     (dcache_block),
    .in_wait          (state_q == ptw_pkg::ST_WAIT)
);

// File: tb/sv39_walker_tb.sv
// Directed bench for sv39_walker: one task per scenario, each self-checking.
module sv39_walker_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [43:0] root_ppn = 44'h100;
    logic        i_req = 1'b0, d_req = 1'b0;
    logic [26:0] i_vpn = '0, d_vpn = '0;
    logic        i_rsp_valid, d_rsp_valid;
    logic [63:0] rsp_pte;
    logic [1:0]  rsp_level;
    logic        rsp_page_fault, rsp_access_fault;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [55:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        dcache_block;

    always #(CLK_PERIOD/2) clk = ~clk;

    sv39_walker u_dut (
        .clk(clk), .rst_n(rst_n), .root_ppn(root_ppn),
        .i_req(i_req), .i_vpn(i_vpn), .i_rsp_valid(i_rsp_valid),
        .d_req(d_req), .d_vpn(d_vpn), .d_rsp_valid(d_rsp_valid),
        .rsp_pte(rsp_pte), .rsp_level(rsp_level),
        .rsp_page_fault(rsp_page_fault), .rsp_access_fault(rsp_access_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
        .dcache_block(dcache_block)
    );

    int n_chk = 0, n_err = 0;

    // Memory model: small table of address/entry pairs, one error address.
    logic [55:0] m_addr [8];
    logic [63:0] m_data [8];
    int          m_n = 0;
    logic [55:0] err_addr = '1;
    logic [55:0] rd_log [8];
    int          rd_n = 0;
    int          stall_left = 0;
    int          stall_bad = 0;
    logic [55:0] stall_addr;
    bit          stall_seen = 0;
    bit          rsp_due = 0;
    logic [55:0] rsp_addr;

    function automatic logic [55:0] ent_pa(input logic [43:0] ppn, input logic [26:0] vpn, input int lvl);
        logic [8:0] idx;
        idx = 9'((vpn >> (9*lvl)) & 27'h1ff);
        return {ppn, 12'h000} + 56'(idx) * 56'd8;
    endfunction

    function automatic logic [26:0] mk_vpn(input int a, input int b, input int c);
        return {9'(a), 9'(b), 9'(c)};
    endfunction

    function automatic logic [63:0] mk_pte(input logic [43:0] ppn, input logic [9:0] flags);
        return {10'h0, ppn, flags};
    endfunction

    function automatic logic [63:0] mem_look(input logic [55:0] a);
        for (int k = 0; k < m_n; k++) if (m_addr[k] == a) return m_data[k];
        return 64'h0;
    endfunction

    task automatic mem_put(input logic [55:0] a, input logic [63:0] d);
        m_addr[m_n] = a;
        m_data[m_n] = d;
        m_n++;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory responder, acting on falling edges only.
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_due) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_err   = (rsp_addr == err_addr);
                mem_rsp_data  = mem_look(rsp_addr);
                rsp_due       = 0;
            end else begin
                mem_rsp_valid = 1'b0;
                mem_rsp_err   = 1'b0;
                mem_rsp_data  = '0;
            end
            if (mem_req_valid) begin
                if (stall_left > 0) begin
                    if (stall_seen && stall_addr != mem_req_addr) stall_bad++;
                    stall_seen    = 1;
                    stall_addr    = mem_req_addr;
                    mem_req_ready = 1'b0;
                    stall_left--;
                end else begin
                    if (stall_seen && stall_addr != mem_req_addr) stall_bad++;
                    stall_seen    = 0;
                    mem_req_ready = 1'b1;
                    if (rd_n < 8) rd_log[rd_n] = mem_req_addr;
                    rd_n++;
                    rsp_due  = 1;
                    rsp_addr = mem_req_addr;
                end
            end else begin
                mem_req_ready = 1'b1;
            end
        end
    end

    // Run one walk on one side and compare its response.
    task automatic run_walk(input bit side_d, input logic [26:0] vpn,
                            input logic [63:0] e_pte, input logic [1:0] e_lvl,
                            input bit e_pf, input bit e_af, input int e_reads,
                            input string req);
        int  guard = 0;
        bit  blk_seen = 0;
        bit  blk_bad = 0;
        rd_n = 0;
        @(negedge clk);
        if (side_d) begin d_req = 1'b1; d_vpn = vpn; end
        else        begin i_req = 1'b1; i_vpn = vpn; end
        do begin
            @(negedge clk);
            guard++;
            if (mem_req_valid) begin
                blk_seen = 1;
                if (dcache_block != side_d) blk_bad = 1;
            end
        end while (!(i_rsp_valid || d_rsp_valid) && guard < 200);
        chk(guard < 200, req, "response arrived", 64'(guard), 64'd200);
        chk(side_d ? (d_rsp_valid && !i_rsp_valid) : (i_rsp_valid && !d_rsp_valid),
            "R8", "strobe on owner side", {62'd0, d_rsp_valid, i_rsp_valid},
            side_d ? 64'd2 : 64'd1);
        chk(rsp_page_fault == e_pf && rsp_access_fault == e_af, req, "fault flags",
            {62'd0, rsp_page_fault, rsp_access_fault}, {62'd0, e_pf, e_af});
        if (!e_pf && !e_af) begin
            chk(rsp_pte == e_pte, req, "leaf entry", rsp_pte, e_pte);
            chk(rsp_level == e_lvl, req, "leaf level", 64'(rsp_level), 64'(e_lvl));
        end
        chk(rd_n == e_reads, req, "number of reads", 64'(rd_n), 64'(e_reads));
        chk(rd_n > 0 && rd_log[0] == ent_pa(root_ppn, vpn, 2), "R1", "first read address",
            64'(rd_log[0]), 64'(ent_pa(root_ppn, vpn, 2)));
        chk(blk_seen && !blk_bad && dcache_block == side_d, "R10", "cache block level",
            {62'd0, blk_bad, dcache_block}, {63'd0, side_d});
        d_req = 1'b0;
        i_req = 1'b0;
        @(negedge clk);
        chk(!i_rsp_valid && !d_rsp_valid && !dcache_block, "R8", "single-cycle response",
            {61'd0, i_rsp_valid, d_rsp_valid, dcache_block}, 64'd0);
    endtask

    localparam logic [43:0] P_L1 = 44'h200;
    localparam logic [43:0] P_L0 = 44'h300;

    // R11: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!mem_req_valid && !i_rsp_valid && !d_rsp_valid && !dcache_block, "R11",
            "idle during reset", {60'd0, mem_req_valid, i_rsp_valid, d_rsp_valid, dcache_block}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req_valid && !i_rsp_valid && !d_rsp_valid && !dcache_block, "R11",
            "idle after reset", {60'd0, mem_req_valid, i_rsp_valid, d_rsp_valid, dcache_block}, 64'd0);
    endtask

    // R1 R3: full three-level data walk to a 4 KiB leaf, every address checked.
    task automatic t_small_page();
        logic [26:0] v = mk_vpn(1, 2, 3);
        run_walk(1, v, mk_pte(44'h12345, 10'h0CF), 2'd0, 0, 0, 3, "R3");
        chk(rd_log[1] == ent_pa(P_L1, v, 1), "R1", "level 1 address", 64'(rd_log[1]), 64'(ent_pa(P_L1, v, 1)));
        chk(rd_log[2] == ent_pa(P_L0, v, 0), "R1", "level 0 address", 64'(rd_log[2]), 64'(ent_pa(P_L0, v, 0)));
    endtask

    // R3: instruction walk ending at an aligned 2 MiB leaf.
    task automatic t_mid_page();
        run_walk(0, mk_vpn(1, 5, 9), mk_pte(44'h400, 10'h049), 2'd1, 0, 0, 2, "R3");
    endtask

    // R6: misaligned 1 GiB leaf.
    task automatic t_misaligned();
        run_walk(1, mk_vpn(3, 0, 0), 64'h0, 2'd0, 1, 0, 1, "R6");
    endtask

    // R5: entry with valid clear, then write-without-read.
    task automatic t_invalid();
        run_walk(0, mk_vpn(4, 0, 0), 64'h0, 2'd0, 1, 0, 1, "R5");
        run_walk(1, mk_vpn(5, 0, 0), 64'h0, 2'd0, 1, 0, 1, "R5");
    endtask

    // R7: pointer at the last level.
    task automatic t_pointer_at_leaf_level();
        run_walk(1, mk_vpn(1, 2, 7), 64'h0, 2'd0, 1, 0, 3, "R7");
    endtask

    // R4: bus error on the level 1 read.
    task automatic t_bus_error();
        logic [26:0] v = mk_vpn(1, 6, 0);
        err_addr = ent_pa(P_L1, v, 1);
        run_walk(0, v, 64'h0, 2'd0, 0, 1, 2, "R4");
        err_addr = '1;
    endtask

    // R2: memory holds off the first request for several cycles.
    task automatic t_stall();
        stall_bad  = 0;
        stall_left = 4;
        run_walk(1, mk_vpn(1, 5, 1), mk_pte(44'h400, 10'h049), 2'd1, 0, 0, 2, "R2");
        chk(stall_bad == 0 && stall_left == 0, "R2", "address held under stall",
            64'(stall_bad), 64'd0);
    endtask

    // R9 R10: both sides request in the same cycle.
    task automatic t_both();
        int  guard = 0;
        bit  blk_bad = 0;
        logic [26:0] vd = mk_vpn(1, 2, 3);
        logic [26:0] vi = mk_vpn(1, 5, 4);
        rd_n = 0;
        @(negedge clk);
        d_req = 1'b1; d_vpn = vd;
        i_req = 1'b1; i_vpn = vi;
        do begin @(negedge clk); guard++; end
        while (!(i_rsp_valid || d_rsp_valid) && guard < 200);
        chk(d_rsp_valid && !i_rsp_valid, "R9", "data side answered first",
            {62'd0, d_rsp_valid, i_rsp_valid}, 64'd2);
        chk(rsp_level == 2'd0 && rsp_pte == mk_pte(44'h12345, 10'h0CF), "R9", "data result",
            rsp_pte, mk_pte(44'h12345, 10'h0CF));
        chk(rd_n == 3 && rd_log[0] == ent_pa(root_ppn, vd, 2), "R9", "data walk reads",
            64'(rd_log[0]), 64'(ent_pa(root_ppn, vd, 2)));
        d_req = 1'b0;
        rd_n  = 0;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
            if (dcache_block) blk_bad = 1;
        end while (!(i_rsp_valid || d_rsp_valid) && guard < 200);
        chk(i_rsp_valid && !d_rsp_valid, "R9", "held instruction request served",
            {62'd0, d_rsp_valid, i_rsp_valid}, 64'd1);
        chk(rsp_level == 2'd1 && rsp_pte == mk_pte(44'h400, 10'h049), "R9", "instruction result",
            rsp_pte, mk_pte(44'h400, 10'h049));
        chk(rd_n == 2 && rd_log[1] == ent_pa(P_L1, vi, 1), "R1", "instruction walk addresses",
            64'(rd_log[1]), 64'(ent_pa(P_L1, vi, 1)));
        chk(!blk_bad, "R10", "no block during instruction walk", 64'(blk_bad), 64'd0);
        i_req = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        mem_put(ent_pa(44'h100, mk_vpn(1, 0, 0), 2), mk_pte(P_L1, 10'h001));
        mem_put(ent_pa(P_L1, mk_vpn(0, 2, 0), 1), mk_pte(P_L0, 10'h001));
        mem_put(ent_pa(P_L0, mk_vpn(0, 0, 3), 0), mk_pte(44'h12345, 10'h0CF));
        mem_put(ent_pa(P_L1, mk_vpn(0, 5, 0), 1), mk_pte(44'h400, 10'h049));
        mem_put(ent_pa(44'h100, mk_vpn(3, 0, 0), 2), mk_pte(44'h401, 10'h0C3));
        mem_put(ent_pa(44'h100, mk_vpn(5, 0, 0), 2), mk_pte(44'h500, 10'h005));
        mem_put(ent_pa(P_L0, mk_vpn(0, 0, 7), 0), mk_pte(44'h600, 10'h001));
        t_reset();
        t_small_page();
        t_mid_page();
        t_misaligned();
        t_invalid();
        t_pointer_at_leaf_level();
        t_bus_error();
        t_stall();
        t_both();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule